// File: doc/BRIEF.md
# Start-Convert Sequencer with Result Latency Tracking

This block is the digital timing core of a pipelined sampling converter. It watches an asynchronous start-convert line, brings it into the system clock domain and reacts only to its rising edge. Each accepted edge raises a busy flag (`eoc`) for a fixed number of clock cycles and captures the sample word offered by the abstract converter core. When the busy window ends, the captured word enters a result pipeline. The word leaving the pipeline is placed on the output register together with a data-valid flag.

If a start edge arrives while a conversion is still running, the running conversion is abandoned and a new one starts at once. The results that are disturbed by this are marked invalid as they pass through the pipeline. Requests to enable the output or to invert its coding are taken only while the block is idle. A request that arrives during a busy window waits until `eoc` has fallen.

A system integrator drives `start_cvt` from a sampling clock. The integrator reads `dout` and `dout_valid` after each falling edge of `eoc` and keeps in mind that each result belongs to the conversion started three conversions earlier.

Top module: `conv_sequencer`

## Requirements
- R1: `start_cvt` passes through two synchronizer flops and an edge detector. When it rises after having been low, `eoc` is seen high in the third clock cycle after the input change.
- R2: Only the rising edge of `start_cvt` matters. Holding it high for many cycles produces exactly one conversion, and `eoc` stays low after that conversion even though the input is still high.
- R3: `eoc` stays high for exactly EOC_CYCLES clock cycles (10 by default) after an accepted start, then falls.
- R4: The result pipeline is PIPE_DEPTH (3) entries deep. On the falling edge of `eoc` for conversion k, the output register takes the word captured for conversion k-3. For the first three conversions after reset it shows an invalid entry, so the fourth start is the first to make a valid result appear.
- R5: `dout` and `dout_valid` do not change while `eoc` stays high. The pipeline moves only in the cycle in which `eoc` falls.
- R6: A start edge accepted while `eoc` is high keeps `eoc` high and restarts the window. `eoc` then falls EOC_CYCLES cycles after the new start is accepted.
- R7: After such a restart, the result pushed when the restarted conversion completes and the result of the conversion after it both carry `dout_valid` = 0 when they reach the output. Later results are valid again.
- R8: `oe_req` and `invert_req` are sampled only on clock edges where `eoc` was low. A change made while `eoc` is high takes effect one cycle after `eoc` falls. `dout` is zero while the output is disabled. While the output is enabled, `dout` is the bitwise complement of the stored word when invert is active, and the stored word itself otherwise.
- R9: A synchronous active-high `rst` drives `eoc` low, empties the pipeline (all entries invalid, `dout_valid` = 0) and disables the output.
- R10: The sample word is captured on the clock edge that accepts a start. Changes on `core_data` during the busy window do not affect the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_cvt | input | 1 | Asynchronous start-convert line; its rising edge starts a conversion |
| core_data | input | DATA_W | Sample word offered by the converter core |
| oe_req | input | 1 | Output enable request, applied only while idle |
| invert_req | input | 1 | Output complement request, applied only while idle |
| eoc | output | 1 | High while a conversion is in progress |
| dout | output | DATA_W | Output register contents after enable and coding |
| dout_valid | output | 1 | Validity of the word currently in the output register |

## Verification
The bench measures the synchronizer delay and the busy-window length cycle by cycle. An extra or missing flop, or a counter that is off by one, shows up as a rise or fall one cycle out of place. It holds start-convert high far beyond one window, so a level-sensitive design would show a second busy period. A restart placed in the middle of a window must stretch `eoc` by a full new window and then yield exactly two invalid results three conversions later; a design that poisons one entry, three entries or the wrong entries shows a wrong valid flag at a known completion. It also changes `core_data` and the invert request while `eoc` is high, which catches designs that latch the sample late or let control changes leak into a busy window. Finally, it resets the block in mid-stream and checks that the pipeline refills from empty.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   // Number of completions flagged invalid after an early restart
   localparam int unsigned POISON_SPAN = 2;

   // Bits needed to hold the values 0..n
   function automatic int unsigned span_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef struct packed {
      logic oe;
      logic invert;
   } out_ctl_t;

endpackage

// File: rtl/cs_sync_edge.sv
module cs_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= async_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= {sync_q[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cs_busy_timer.sv
module cs_busy_timer #(
   parameter int unsigned CYCLES = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic eoc,
   output logic restart,
   output logic done
);
   localparam int unsigned CW = conv_seq_pkg::span_bits(CYCLES - 1);

   logic [CW-1:0] left_q;

   assign restart = start & eoc;
   assign done    = eoc & ~start & (left_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         eoc    <= 1'b0;
         left_q <= '0;
      end else if (start) begin
         eoc    <= 1'b1;
         left_q <= CW'(CYCLES - 1);
      end else if (done) begin
         eoc    <= 1'b0;
      end else if (eoc) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/cs_result_pipe.sv
module cs_result_pipe #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         accept,
   input  logic         restart,
   input  logic         done,
   input  logic [W-1:0] sample,
   output logic [W-1:0] res_data,
   output logic         res_valid
);
   import conv_seq_pkg::*;

   localparam int unsigned PW = span_bits(POISON_SPAN);

   logic [W-1:0]  cap_q;
   logic [PW-1:0] poison_q;
   logic          new_valid;
   logic [W-1:0]  tail_data;
   logic          tail_valid;

   assign new_valid = (poison_q == '0);

   always_ff @(posedge clk) begin
      if (rst)         cap_q <= '0;
      else if (accept) cap_q <= sample;
   end

   always_ff @(posedge clk) begin
      if (rst)                          poison_q <= '0;
      else if (restart)                 poison_q <= PW'(POISON_SPAN);
      else if (done && poison_q != '0)  poison_q <= poison_q - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_one
         logic [W-1:0] st_d;
         logic         st_v;
         always_ff @(posedge clk) begin
            if (rst) begin
               st_d <= '0;
               st_v <= 1'b0;
            end else if (done) begin
               st_d <= cap_q;
               st_v <= new_valid;
            end
         end
         assign tail_data  = st_d;
         assign tail_valid = st_v;
      end else begin : g_shift
         logic [DEPTH-1:0][W-1:0] st_d;
         logic [DEPTH-1:0]        st_v;
         always_ff @(posedge clk) begin
            if (rst) begin
               st_d <= '0;
               st_v <= '0;
            end else if (done) begin
               for (int g = DEPTH - 1; g > 0; g--) begin
                  st_d[g] <= st_d[g-1];
                  st_v[g] <= st_v[g-1];
               end
               st_d[0] <= cap_q;
               st_v[0] <= new_valid;
            end
         end
         assign tail_data  = st_d[DEPTH-1];
         assign tail_valid = st_v[DEPTH-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         res_data  <= '0;
         res_valid <= 1'b0;
      end else if (done) begin
         res_data  <= tail_data;
         res_valid <= tail_valid;
      end
   end
endmodule

// File: rtl/cs_out_stage.sv
module cs_out_stage #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         eoc,
   input  logic         oe_req,
   input  logic         invert_req,
   input  logic [W-1:0] res_data,
   output logic [W-1:0] dout,
   output logic         oe_active
);
   import conv_seq_pkg::*;

   out_ctl_t ctl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
      end else if (!eoc) begin
         ctl_q.oe     <= oe_req;
         ctl_q.invert <= invert_req;
      end
   end

   always_comb begin
      if (!ctl_q.oe)         dout = '0;
      else if (ctl_q.invert) dout = ~res_data;
      else                   dout = res_data;
   end

   assign oe_active = ctl_q.oe;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned EOC_CYCLES  = 10,
   parameter int unsigned PIPE_DEPTH  = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_cvt,
   input  logic [DATA_W-1:0] core_data,
   input  logic              oe_req,
   input  logic              invert_req,
   output logic              eoc,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid
);
   initial begin
      if (DATA_W < 1)      $fatal(1, "DATA_W must be at least 1");
      if (EOC_CYCLES < 1)  $fatal(1, "EOC_CYCLES must be at least 1");
      if (PIPE_DEPTH < 1)  $fatal(1, "PIPE_DEPTH must be at least 1");
      if (SYNC_STAGES < 2) $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic              start_rise;
   logic              restart_w;
   logic              done_w;
   logic [DATA_W-1:0] res_data;
   logic              ctl_oe;

   cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (start_cvt),
      .rise     (start_rise)
   );

   cs_busy_timer #(.CYCLES(EOC_CYCLES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (start_rise),
      .eoc     (eoc),
      .restart (restart_w),
      .done    (done_w)
   );

   cs_result_pipe #(.W(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
      .clk       (clk),
      .rst       (rst),
      .accept    (start_rise),
      .restart   (restart_w),
      .done      (done_w),
      .sample    (core_data),
      .res_data  (res_data),
      .res_valid (dout_valid)
   );

   cs_out_stage #(.W(DATA_W)) u_out (
      .clk        (clk),
      .rst        (rst),
      .eoc        (eoc),
      .oe_req     (oe_req),
      .invert_req (invert_req),
      .res_data   (res_data),
      .dout       (dout),
      .oe_active  (ctl_oe)
   );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned EOC_CYCLES = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              start_evt,
   input logic              eoc,
   input logic [DATA_W-1:0] dout,
   input logic              dout_valid,
   input logic              oe_on
);
   localparam int unsigned HW = $clog2(EOC_CYCLES + 2) + 1;
   localparam logic [HW-1:0] HMAX = '1;

   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (rst)                          hi_cnt <= '0;
      else if (start_evt)               hi_cnt <= HW'(1);
      else if (eoc && hi_cnt != HMAX)   hi_cnt <= hi_cnt + 1'b1;
      else if (!eoc)                    hi_cnt <= '0;
   end

   // R9: reset forces idle and an empty output
   p_reset_idle_r9: assert property (@(posedge clk)
      rst |=> (!eoc && !dout_valid));

   // R1: busy only begins from a detected start edge
   p_rise_from_edge_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(eoc) |-> $past(start_evt));

   // R3: window never exceeds its length
   p_window_bound_r3: assert property (@(posedge clk) disable iff (rst)
      eoc |-> (hi_cnt <= HW'(EOC_CYCLES)));

   // R3: window ends after exactly its length
   p_window_exact_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(eoc) |-> ($past(hi_cnt) == HW'(EOC_CYCLES)));

   // R6: an edge during busy keeps busy asserted
   p_restart_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (start_evt && eoc) |=> eoc);

   // R5: output register frozen inside a busy window
   p_busy_frozen_r5: assert property (@(posedge clk) disable iff (rst)
      (eoc && $past(eoc)) |-> ($stable(dout) && $stable(dout_valid)));

   // R4: validity moves only with a completed conversion
   p_valid_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
      !$stable(dout_valid) |-> ($fell(eoc) || $past(rst)));

   // R8: enable state held through a busy window
   p_ctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (eoc && $past(eoc)) |-> $stable(oe_on));
endmodule

bind conv_sequencer conv_sequencer_chk #(
   .DATA_W     (DATA_W),
   .EOC_CYCLES (EOC_CYCLES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start_evt  (start_rise),
   .eoc        (eoc),
   .dout       (dout),
   .dout_valid (dout_valid),
   .oe_on      (ctl_oe)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 16;
   localparam int EOC = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_cvt = 1'b0;
   logic [W-1:0] core_data = '0;
   logic         oe_req = 1'b0;
   logic         invert_req = 1'b0;
   logic         eoc;
   logic [W-1:0] dout;
   logic         dout_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [W-1:0] m_d[$];
   bit           m_v[$];
   int           m_poison = 0;
   bit           m_oe = 0;
   bit           m_inv = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_sequencer #(.DATA_W(W), .EOC_CYCLES(EOC)) u_conv_sequencer (
      .clk        (clk),
      .rst        (rst),
      .start_cvt  (start_cvt),
      .core_data  (core_data),
      .oe_req     (oe_req),
      .invert_req (invert_req),
      .eoc        (eoc),
      .dout       (dout),
      .dout_valid (dout_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model_push(input logic [W-1:0] d);
      m_d.push_back(d);
      m_v.push_back(m_poison == 0);
      if (m_poison > 0) m_poison--;
   endfunction

   task automatic check_out(input string req);
      int k;
      bit ev;
      logic [W-1:0] ed;
      k = m_d.size();
      ev = 0;
      ed = '0;
      if (k >= 4) begin
         ev = m_v[k-4];
         ed = m_d[k-4];
      end
      chk(dout_valid == ev, req, "dout_valid", 32'(dout_valid), 32'(ev));
      if (!m_oe)
         chk(dout == '0, req, "dout disabled", 32'(dout), 0);
      else if (ev)
         chk(dout == (m_inv ? ~ed : ed), req, "dout word", 32'(dout), 32'(m_inv ? ~ed : ed));
   endtask

   task automatic set_ctl(input bit oe, input bit inv);
      @(negedge clk);
      oe_req = oe;
      invert_req = inv;
      @(negedge clk);
      @(negedge clk);
      m_oe = oe;
      m_inv = inv;
   endtask

   // One conversion: start held for 'hold' cycles, optional invert flip while busy
   task automatic conv(input logic [W-1:0] d, input int hold, input bit flip);
      int i;
      int rise_at;
      int high_cnt;
      int extra_hi;
      bit fell;
      logic [W-1:0] held_d;
      logic held_v;
      i = 0; rise_at = -1; high_cnt = 0; extra_hi = 0; fell = 0;
      held_d = '0; held_v = 0;
      @(negedge clk);
      core_data = d;
      start_cvt = 1'b1;
      while (!fell || i < hold) begin
         @(negedge clk);
         i++;
         if (i == hold) start_cvt = 1'b0;
         if (eoc) begin
            if (fell) extra_hi++;
            else begin
               high_cnt++;
               if (rise_at < 0) begin
                  rise_at = i;
                  held_d = dout;
                  held_v = dout_valid;
                  core_data = ~d;  // R10: late change must not be stored
               end else begin
                  chk(dout == held_d && dout_valid == held_v, "R5",
                      "output moved while busy", 32'(dout), 32'(held_d));
               end
               if (flip && high_cnt == 5) invert_req = ~invert_req;
            end
         end else if (rise_at >= 0) begin
            fell = 1;
         end
         if (i > 200) begin
            fell = 1;
            i = hold;
         end
      end
      start_cvt = 1'b0;
      chk(rise_at == 3, "R1", "eoc rise cycle", 32'(rise_at), 3);
      chk(high_cnt == EOC, "R3", "eoc high cycles", 32'(high_cnt), EOC);
      if (hold > EOC)
         chk(extra_hi == 0, "R2", "eoc again while start held", 32'(extra_hi), 0);
      model_push(d);
      check_out("R4 R10");
   endtask

   // Start, then a second edge inside the busy window
   task automatic restart_conv(input logic [W-1:0] da, input logic [W-1:0] db);
      int first_low;
      int hi;
      @(negedge clk);
      core_data = da;
      start_cvt = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start_cvt = 1'b0;
      hi = 0;
      while (hi < 3) begin
         @(negedge clk);
         if (eoc) hi++;
      end
      core_data = db;
      start_cvt = 1'b1;
      first_low = 0;
      for (int j = 1; j <= 20; j++) begin
         @(negedge clk);
         if (j == 2) start_cvt = 1'b0;
         if (!eoc && first_low == 0) first_low = j;
      end
      chk(first_low == 13, "R6", "eoc fall after restart", 32'(first_low), 13);
      m_poison = 2;
      model_push(db);
      check_out("R7");
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(eoc == 1'b0, "R9", "eoc in reset", 32'(eoc), 0);
      chk(dout_valid == 1'b0, "R9", "valid in reset", 32'(dout_valid), 0);
      chk(dout == '0, "R9", "dout in reset", 32'(dout), 0);
      rst = 1'b0;
      m_d.delete();
      m_v.delete();
      m_poison = 0;
      m_oe = 0;
      m_inv = 0;
   endtask

   task automatic t_latency();
      set_ctl(1, 0);
      conv(16'h1234, 2, 0);
      conv(16'hA5A5, 2, 0);
      conv(16'h0F0F, 2, 0);
      conv(16'hBEEF, 2, 0);  // R4: first valid word here
      chk(dout_valid == 1'b1, "R4", "first valid after fourth", 32'(dout_valid), 1);
      conv(16'h0001, 2, 0);
   endtask

   task automatic t_level_hold();
      conv(16'h7777, 30, 0);  // R2
   endtask

   task automatic t_invert();
      set_ctl(1, 1);
      conv(16'h00FF, 2, 0);   // R8 inverted coding
      conv(16'h3C3C, 2, 1);   // R8 flip during busy, old coding at fall
      @(negedge clk);
      m_inv = invert_req;
      check_out("R8");
      set_ctl(0, 0);
      conv(16'h5555, 2, 0);   // R8 disabled output reads zero
      set_ctl(1, 0);
      check_out("R8");
   endtask

   task automatic t_restart();
      restart_conv(16'hDEAD, 16'hCAFE);
      for (int n = 0; n < 5; n++) conv(16'h1000 + 16'(n), 2, 0);  // R7 invalid pair appears
   endtask

   task automatic t_midreset();
      t_reset();
      set_ctl(1, 0);
      for (int n = 0; n < 4; n++) conv(16'h8000 + 16'(n), 2, 0);
      chk(dout == 16'h8000, "R9", "refill after reset", 32'(dout), 32'h8000);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_level_hold();
      t_invert();
      t_restart();
      t_midreset();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule